// File: doc/BRIEF.md
# Segment Address Translator with Bounds and Access Checks

This block turns a segmented logical address into a physical one. The logical address has two parts: a segment selector that picks one entry of a small table held in flip-flops, and an offset within that segment. Each table entry holds a physical start address, a segment length, a valid flag and three privilege flags (read, write, execute). A lookup is purely combinational and completes in the same cycle. It returns either the physical address (start address plus offset) or a two-bit fault code that says why the access was refused.

The operating system fills the table through a write port. It writes one whole entry per clock, and the new entry becomes visible on the following cycle. Array bounds and code/data separation are therefore checked on every access with no software involvement. A fault on a bad index, an overrun or a forbidden access type can be raised directly by the requester.

Top module: `seg_xlate`

## Requirements
- R1: A lookup is combinational: `lk_pa` and `lk_fault` reflect `lk_seg` (4-bit table index), `lk_off` (16-bit offset) and `lk_acc` in the same cycle, with no clock edge in between.
- R2: When no fault applies, `lk_fault` is 00 and `lk_pa` equals the entry's base plus the zero-extended offset, taken modulo 2^24.
- R3: A lookup of an entry whose valid flag is 0 returns fault 01.
- R4: A lookup whose offset is greater than or equal to the entry's 16-bit limit returns fault 10. An offset of limit-1 is legal.
- R5: Privilege bits are bit 0 = read, bit 1 = write, bit 2 = execute. Access code 00 = read, 01 = write, 10 = execute, and 11 is reserved. An access whose matching privilege bit is clear, or any access with code 11, returns fault 11.
- R6: When several faults apply, the reported code follows the priority invalid (01), then limit (10), then permission (11).
- R7: A table write (`wr_en` high at a rising edge) takes effect from the next cycle. A lookup of the same entry in the write cycle returns the old contents.
- R8: Reset (asynchronous, active low) leaves every entry invalid, so every lookup returns fault 01 until that entry is written.
- R9: Whenever `lk_fault` is nonzero, `lk_pa` is zero.
- R10: A write changes only the entry selected by `wr_seg`. All other entries keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one table entry at this edge |
| wr_seg | input | 4 | Index of the entry to write |
| wr_base | input | 24 | Physical start address to store |
| wr_limit | input | 16 | Segment length to store |
| wr_valid | input | 1 | Valid flag to store |
| wr_perm | input | 3 | Privileges to store: bit0 read, bit1 write, bit2 execute |
| lk_seg | input | 4 | Segment selector of the lookup |
| lk_off | input | 16 | Offset of the lookup |
| lk_acc | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 reserved |
| lk_pa | output | 24 | Translated physical address, zero on a fault |
| lk_fault | output | 2 | 00 none, 01 invalid, 10 limit, 11 permission |

## Verification
A corrupted table entry has no effect until that exact segment is looked up. Because the lookup is combinational, the damage then appears in the same cycle, either as a shifted address or as the wrong fault code. The stimulus therefore revisits each written entry with offsets at limit-1 and at the limit, and with every access kind. A write that lands in the wrong entry, or that becomes visible one cycle early or late, shows on the first lookup after it. The bench therefore probes the written index both in the write cycle and in the cycle after, and probes a different entry as well.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'b00,
    FLT_INVALID = 2'b01,
    FLT_LIMIT   = 2'b10,
    FLT_PERM    = 2'b11
  } flt_e;

  typedef enum logic [1:0] {
    ACC_RD  = 2'b00,
    ACC_WR  = 2'b01,
    ACC_EX  = 2'b10,
    ACC_RSV = 2'b11
  } acc_e;

  localparam int unsigned PERM_W   = 3;
  localparam int unsigned PERM_RD  = 0;
  localparam int unsigned PERM_WR  = 1;
  localparam int unsigned PERM_EX  = 2;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int unsigned SEGW = 4,
  parameter int unsigned OFFW = 16,
  parameter int unsigned PAW  = 24
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [SEGW-1:0]                       wr_seg,
  input  logic [PAW-1:0]                        wr_base,
  input  logic [OFFW-1:0]                       wr_limit,
  input  logic                                  wr_valid,
  input  logic [seg_xlate_pkg::PERM_W-1:0]      wr_perm,
  input  logic [SEGW-1:0]                       rd_seg,
  output logic [PAW-1:0]                        rd_base,
  output logic [OFFW-1:0]                       rd_limit,
  output logic                                  rd_valid,
  output logic [seg_xlate_pkg::PERM_W-1:0]      rd_perm
);
  import seg_xlate_pkg::*;

  localparam int unsigned NSEG = 1 << SEGW;

  logic [PAW-1:0]    base_arr  [NSEG];
  logic [OFFW-1:0]   limit_arr [NSEG];
  logic              valid_arr [NSEG];
  logic [PERM_W-1:0] perm_arr  [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    logic              sel;
    logic [PAW-1:0]    base_d,  base_q;
    logic [OFFW-1:0]   limit_d, limit_q;
    logic              valid_d, valid_q;
    logic [PERM_W-1:0] perm_d,  perm_q;

    assign sel = wr_en && (wr_seg == SEGW'(g));

    always_comb begin
      base_d  = wr_base;
      limit_d = wr_limit;
      valid_d = wr_valid;
      perm_d  = wr_perm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q  <= '0;
        limit_q <= '0;
        valid_q <= 1'b0;
        perm_q  <= '0;
      end else if (sel) begin
        base_q  <= base_d;
        limit_q <= limit_d;
        valid_q <= valid_d;
        perm_q  <= perm_d;
      end
    end

    assign base_arr[g]  = base_q;
    assign limit_arr[g] = limit_q;
    assign valid_arr[g] = valid_q;
    assign perm_arr[g]  = perm_q;
  end

  assign rd_base  = base_arr[rd_seg];
  assign rd_limit = limit_arr[rd_seg];
  assign rd_valid = valid_arr[rd_seg];
  assign rd_perm  = perm_arr[rd_seg];

endmodule

// File: rtl/seg_check.sv
module seg_check #(
  parameter int unsigned OFFW = 16,
  parameter int unsigned PAW  = 24
) (
  input  logic [PAW-1:0]                   ent_base,
  input  logic [OFFW-1:0]                  ent_limit,
  input  logic                             ent_valid,
  input  logic [seg_xlate_pkg::PERM_W-1:0] ent_perm,
  input  logic [OFFW-1:0]                  off,
  input  logic [1:0]                       acc,
  output logic [PAW-1:0]                   pa,
  output logic [1:0]                       fault
);
  import seg_xlate_pkg::*;

  localparam int unsigned PADW = PAW - OFFW;

  acc_e        acc_k;
  logic        allowed;
  logic        in_range;
  flt_e        flt;
  logic [PAW-1:0] sum;

  assign acc_k    = acc_e'(acc);
  assign in_range = off < ent_limit;
  assign sum      = ent_base + {{PADW{1'b0}}, off};

  always_comb begin
    unique case (acc_k)
      ACC_RD:  allowed = ent_perm[PERM_RD];
      ACC_WR:  allowed = ent_perm[PERM_WR];
      ACC_EX:  allowed = ent_perm[PERM_EX];
      default: allowed = 1'b0;
    endcase
  end

  always_comb begin
    if (!ent_valid)      flt = FLT_INVALID;
    else if (!in_range)  flt = FLT_LIMIT;
    else if (!allowed)   flt = FLT_PERM;
    else                 flt = FLT_NONE;
  end

  assign fault = flt;
  assign pa    = (flt == FLT_NONE) ? sum : '0;

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int unsigned SEGW = 4,
  parameter int unsigned OFFW = 16,
  parameter int unsigned PAW  = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [SEGW-1:0] wr_seg,
  input  logic [PAW-1:0]  wr_base,
  input  logic [OFFW-1:0] wr_limit,
  input  logic            wr_valid,
  input  logic [2:0]      wr_perm,
  input  logic [SEGW-1:0] lk_seg,
  input  logic [OFFW-1:0] lk_off,
  input  logic [1:0]      lk_acc,
  output logic [PAW-1:0]  lk_pa,
  output logic [1:0]      lk_fault
);
  import seg_xlate_pkg::*;

  logic [PAW-1:0]    e_base;
  logic [OFFW-1:0]   e_limit;
  logic              e_valid;
  logic [PERM_W-1:0] e_perm;

  seg_table #(.SEGW(SEGW), .OFFW(OFFW), .PAW(PAW)) table_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_seg   (wr_seg),
    .wr_base  (wr_base),
    .wr_limit (wr_limit),
    .wr_valid (wr_valid),
    .wr_perm  (wr_perm),
    .rd_seg   (lk_seg),
    .rd_base  (e_base),
    .rd_limit (e_limit),
    .rd_valid (e_valid),
    .rd_perm  (e_perm)
  );

  seg_check #(.OFFW(OFFW), .PAW(PAW)) check_i (
    .ent_base  (e_base),
    .ent_limit (e_limit),
    .ent_valid (e_valid),
    .ent_perm  (e_perm),
    .off       (lk_off),
    .acc       (lk_acc),
    .pa        (lk_pa),
    .fault     (lk_fault)
  );

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int unsigned SEGW = 4,
  parameter int unsigned OFFW = 16,
  parameter int unsigned PAW  = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [SEGW-1:0] wr_seg,
  input logic [PAW-1:0]  wr_base,
  input logic [OFFW-1:0] wr_limit,
  input logic            wr_valid,
  input logic [2:0]      wr_perm,
  input logic [SEGW-1:0] lk_seg,
  input logic [OFFW-1:0] lk_off,
  input logic [1:0]      lk_acc,
  input logic [PAW-1:0]  lk_pa,
  input logic [1:0]      lk_fault
);

  // R9: a refused access never leaks an address
  p_fault_pa_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_fault != 2'b00) |-> (lk_pa == '0));

  // R3 / R7: an entry just written as invalid reports invalid next cycle
  p_inval_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_valid) |=> ((lk_seg != $past(wr_seg)) || (lk_fault == 2'b01)));

  // R4 / R6: valid entry just written, offset at or past limit -> limit fault
  p_limit_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_valid) |=>
      ((lk_seg != $past(wr_seg)) || (lk_off < $past(wr_limit)) || (lk_fault == 2'b10)));

  // R2 / R7: fully privileged entry just written, in-range offset -> base + offset
  p_translate_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_valid && (wr_perm == 3'b111)) |=>
      ((lk_seg != $past(wr_seg)) || (lk_off >= $past(wr_limit)) || (lk_acc == 2'b11) ||
       ((lk_fault == 2'b00) && (lk_pa == PAW'($past(wr_base) + PAW'(lk_off))))));

  // R5: the reserved access code is never granted
  p_reserved_acc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_acc == 2'b11) |-> (lk_fault != 2'b00));

endmodule

bind seg_xlate seg_xlate_chk #(.SEGW(SEGW), .OFFW(OFFW), .PAW(PAW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_seg   (wr_seg),
  .wr_base  (wr_base),
  .wr_limit (wr_limit),
  .wr_valid (wr_valid),
  .wr_perm  (wr_perm),
  .lk_seg   (lk_seg),
  .lk_off   (lk_off),
  .lk_acc   (lk_acc),
  .lk_pa    (lk_pa),
  .lk_fault (lk_fault)
);

// File: tb/seg_xlate_tb_top.sv
module seg_xlate_tb_top;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_seg;
  logic [23:0] wr_base;
  logic [15:0] wr_limit;
  logic        wr_valid;
  logic [2:0]  wr_perm;
  logic [3:0]  lk_seg;
  logic [15:0] lk_off;
  logic [1:0]  lk_acc;
  logic [23:0] lk_pa;
  logic [1:0]  lk_fault;

  int checks;
  int failures;
  bit done;

  seg_xlate dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_seg(wr_seg), .wr_base(wr_base), .wr_limit(wr_limit),
    .wr_valid(wr_valid), .wr_perm(wr_perm),
    .lk_seg(lk_seg), .lk_off(lk_off), .lk_acc(lk_acc),
    .lk_pa(lk_pa), .lk_fault(lk_fault)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [3:0]  seg;
    logic [15:0] off;
    logic [1:0]  acc;
    logic [1:0]  fault;
    logic [23:0] pa;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 16'h0000, 2'b00, 2'b00, 24'h100000, 4'd2},  // R2 start of seg1
    '{4'd1, 16'h0FFF, 2'b01, 2'b00, 24'h100FFF, 4'd4},  // R4 limit-1 legal
    '{4'd1, 16'h1000, 2'b00, 2'b10, 24'h000000, 4'd4},  // R4 at limit
    '{4'd1, 16'h0010, 2'b10, 2'b11, 24'h000000, 4'd5},  // R5 exec denied
    '{4'd2, 16'h1800, 2'b10, 2'b00, 24'h000800, 4'd2},  // R2 wraps mod 2^24
    '{4'd2, 16'h0000, 2'b00, 2'b11, 24'h000000, 4'd5},  // R5 read denied
    '{4'd2, 16'h2000, 2'b00, 2'b10, 24'h000000, 4'd6},  // R6 limit over perm
    '{4'd3, 16'h0000, 2'b00, 2'b01, 24'h000000, 4'd3},  // R3 invalid entry
    '{4'd3, 16'h0100, 2'b10, 2'b01, 24'h000000, 4'd6},  // R6 invalid over limit
    '{4'd5, 16'hFFFE, 2'b00, 2'b00, 24'h133454, 4'd2},  // R2
    '{4'd5, 16'h0001, 2'b11, 2'b11, 24'h000000, 4'd5},  // R5 reserved code
    '{4'd0, 16'h0000, 2'b00, 2'b01, 24'h000000, 4'd10}, // R10 untouched entry
    '{4'd5, 16'hFFFF, 2'b00, 2'b10, 24'h000000, 4'd4}   // R4 max offset
  };

  task automatic check(input string req, input logic [1:0] ef, input logic [23:0] ep);
    checks++;
    if (lk_fault !== ef || lk_pa !== ep) begin
      failures++;
      $display("FAIL %s: fault=%b pa=%h expected fault=%b pa=%h", req, lk_fault, lk_pa, ef, ep);
    end
  endtask

  task automatic write_ent(input logic [3:0] s, input logic [23:0] b, input logic [15:0] l,
                           input logic v, input logic [2:0] p);
    @(negedge clk);
    wr_en = 1'b1; wr_seg = s; wr_base = b; wr_limit = l; wr_valid = v; wr_perm = p;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [3:0] s, input logic [15:0] o, input logic [1:0] a);
    lk_seg = s; lk_off = o; lk_acc = a;
    #2;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; done = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_seg = '0; wr_base = '0; wr_limit = '0;
    wr_valid = 1'b0; wr_perm = '0; lk_seg = '0; lk_off = '0; lk_acc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: after reset every entry is invalid
    look(4'd1, 16'h0000, 2'b00); check("R8", 2'b01, 24'h0);
    look(4'd15, 16'h0000, 2'b10); check("R8", 2'b01, 24'h0);

    write_ent(4'd1, 24'h100000, 16'h1000, 1'b1, 3'b011);
    write_ent(4'd2, 24'hFFF000, 16'h2000, 1'b1, 3'b100);
    write_ent(4'd3, 24'h020000, 16'h0010, 1'b0, 3'b111);
    write_ent(4'd5, 24'h123456, 16'hFFFF, 1'b1, 3'b001);

    for (int i = 0; i < NV; i++) begin
      look(VECS[i].seg, VECS[i].off, VECS[i].acc);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].fault, VECS[i].pa);
    end

    // R1: a change of lookup inputs alone, with no clock edge, changes the result
    @(posedge clk); #1;
    look(4'd1, 16'h0004, 2'b00); check("R1", 2'b00, 24'h100004);
    look(4'd1, 16'h0008, 2'b01); check("R1", 2'b00, 24'h100008);

    // R7: same-cycle lookup sees old contents, next cycle sees new
    @(negedge clk);
    wr_en = 1'b1; wr_seg = 4'd7; wr_base = 24'h000400; wr_limit = 16'h0100;
    wr_valid = 1'b1; wr_perm = 3'b111;
    look(4'd7, 16'h0020, 2'b01); check("R7 old", 2'b01, 24'h0);
    @(negedge clk);
    wr_en = 1'b0;
    look(4'd7, 16'h0020, 2'b01); check("R7 new", 2'b00, 24'h000420);

    // R10: rewriting seg1 as invalid leaves seg5 and seg7 unchanged
    write_ent(4'd1, 24'h100000, 16'h1000, 1'b0, 3'b011);
    look(4'd1, 16'h0000, 2'b00); check("R3 rewrite", 2'b01, 24'h0);
    look(4'd5, 16'h0002, 2'b00); check("R10", 2'b00, 24'h123458);
    look(4'd7, 16'h00FF, 2'b10); check("R10", 2'b00, 24'h0004FF);

    // R9: permission fault yields zero address even inside the range
    look(4'd5, 16'h0002, 2'b01); check("R9", 2'b11, 24'h0);

    // R8: reset in mid-run clears the table
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    look(4'd5, 16'h0002, 2'b00); check("R8 rerun", 2'b01, 24'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule